// File: doc/BRIEF.md
# DMA Bus Cycle Sequencer

This block is the timing and control state machine that runs the bus cycles of one DMA channel. A service request moves it from idle into a bus-request state. It raises the hold request and waits there until the host returns hold acknowledge. It then takes the bus and can pulse the upper-address strobe. Next it drives the read and write strobe pair that the latched transfer type selects. It holds those strobes while READY is low, and it releases them in a final state that marks the end of the transfer.

In block mode the sequencer chains transfers without giving up the bus. Each later transfer skips the upper-address strobe state unless the upper address byte has changed. A verify transfer runs the same states as the other types but asserts no read or write strobe, and READY has no effect on it. Channel arbitration and the data path for memory-to-memory moves are handled outside this block.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the sequencer is idle. hold_req, bus_drive, aen, adstb and xfer_done are 0, and memr_n, memw_n, ior_n and iow_n are 1.
- R2: While idle, bus_drive and aen are 0 and every strobe is inactive, so the bus is released.
- R3: A high svc_req in idle raises hold_req at the next edge. The sequencer keeps hold_req high and the bus released for as long as hold_ack stays low. With hold_ack tied to hold_req, exactly one such request cycle occurs.
- R4: The first edge that sees hold_ack high enters the address-strobe state. In that state adstb is 1 for exactly one cycle, and aen and bus_drive are 1 from that state through the release state.
- R5: A read transfer (xfer_type 2'b10) drives memr_n and iow_n low together in the strobe-assert and wait states, while memw_n and ior_n stay high.
- R6: A write transfer (xfer_type 2'b01) drives ior_n and memw_n low together in those states, while memr_n and iow_n stay high.
- R7: A verify transfer (xfer_type 2'b00, and the unused code 2'b11) asserts no strobe. Its wait state lasts one cycle whatever READY is.
- R8: For read and write transfers, each edge in the wait state that sees ready low adds one cycle in which the strobes stay asserted.
- R9: xfer_done is high for one cycle, in the release state, where all strobes are inactive again.
- R10: If block_mode, svc_req and hold_ack are all high in the release state, the next transfer starts at once without returning to idle. It enters the address-strobe state only when hi_addr_chg is high in that release cycle, and otherwise goes straight to strobe-assert.
- R11: If block_mode or svc_req is low in the release state, the sequencer returns to idle and drops hold_req.
- R12: The transfer type is captured when the bus is granted. A change of xfer_type later in the transfer has no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| svc_req | input | 1 | Service wanted on this channel |
| hold_ack | input | 1 | Host has granted the bus |
| ready | input | 1 | Low inserts wait states |
| xfer_type | input | 2 | 2'b10 read, 2'b01 write, 2'b00 or 2'b11 verify |
| block_mode | input | 1 | Chain transfers without releasing the bus |
| hi_addr_chg | input | 1 | Upper address byte must be re-latched |
| hold_req | output | 1 | Bus request to host |
| bus_drive | output | 1 | Output enable for address and strobe drivers |
| aen | output | 1 | Address enable, active high |
| adstb | output | 1 | Upper-address strobe, active high |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
In the release cycle two functions meet. The transfer-done pulse ends one transfer, and the same cycle decides whether the next block transfer needs the upper-address strobe. The bench holds block mode and the service request high. It raises hi_addr_chg only in the release cycle and expects the following cycle to show the address-strobe outputs. With hi_addr_chg low it expects the following cycle to show the strobe pair directly. A second case drops block_mode with svc_req still high and expects the sequencer to return to idle, not to chain another transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_REQ    = 3'd1,
      ST_ADR    = 3'd2,
      ST_ASSERT = 3'd3,
      ST_WAIT   = 3'd4,
      ST_REL    = 3'd5
   } seq_state_t;

   localparam int TYPE_W = 2;

   typedef enum logic [TYPE_W-1:0] {
      XT_VERIFY = 2'b00,
      XT_WRITE  = 2'b01,
      XT_READ   = 2'b10,
      XT_RSVD   = 2'b11
   } xfer_t;

   localparam int NUM_STROBES = 4;
   localparam int SB_MEMR = 0;
   localparam int SB_MEMW = 1;
   localparam int SB_IOR  = 2;
   localparam int SB_IOW  = 3;

   function automatic logic [NUM_STROBES-1:0] strobe_mask(xfer_t t);
      logic [NUM_STROBES-1:0] m;
      m = '0;
      case (t)
         XT_READ: begin
            m[SB_MEMR] = 1'b1;
            m[SB_IOW]  = 1'b1;
         end
         XT_WRITE: begin
            m[SB_IOR]  = 1'b1;
            m[SB_MEMW] = 1'b1;
         end
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
#(
   parameter bit SKIP_ADSTB = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 svc_req,
   input  logic                 hold_ack,
   input  logic                 ready,
   input  logic                 block_mode,
   input  logic                 hi_addr_chg,
   input  logic [TYPE_W-1:0]    xfer_type,
   output seq_state_t           state,
   output xfer_t                cur_type
);

   seq_state_t state_nx;
   logic       need_adr;
   logic       is_verify;
   logic       chain;

   generate
      if (SKIP_ADSTB) begin : g_skip
         assign need_adr = hi_addr_chg;
      end else begin : g_always
         logic unused_chg;
         assign unused_chg = hi_addr_chg;
         assign need_adr   = 1'b1;
      end
   endgenerate

   assign is_verify = (cur_type != XT_READ) && (cur_type != XT_WRITE);
   assign chain     = block_mode && svc_req && hold_ack;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:   if (svc_req)  state_nx = ST_REQ;
         ST_REQ:    if (hold_ack) state_nx = ST_ADR;
         ST_ADR:    state_nx = ST_ASSERT;
         ST_ASSERT: state_nx = ST_WAIT;
         ST_WAIT:   if (ready || is_verify) state_nx = ST_REL;
         ST_REL: begin
            if (chain) state_nx = need_adr ? ST_ADR : ST_ASSERT;
            else       state_nx = ST_IDLE;
         end
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cur_type <= XT_VERIFY;
      end else begin
         state <= state_nx;
         if (state == ST_REQ && hold_ack)
            cur_type <= xfer_t'(xfer_type);
      end
   end

   AST_VERIFY_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && (cur_type == XT_VERIFY || cur_type == XT_RSVD)) |=> (state == ST_REL)); // R7
   AST_TYPE_HELD: assert property (@(posedge clk) disable iff (rst)
      (state inside {ST_ASSERT, ST_WAIT}) |=> $stable(cur_type)); // R12
   AST_REQ_WAITS: assert property (@(posedge clk) disable iff (rst)
      (state == ST_REQ && !hold_ack) |=> (state == ST_REQ)); // R3

endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
   import dma_seq_pkg::*;
(
   input  seq_state_t              state,
   input  xfer_t                   cur_type,
   output logic [NUM_STROBES-1:0]  strb_act
);

   logic                   phase_on;
   logic [NUM_STROBES-1:0] mask;

   assign phase_on = (state == ST_ASSERT) || (state == ST_WAIT);
   assign mask     = strobe_mask(cur_type);

   for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strb
      assign strb_act[i] = phase_on & mask[i];
   end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
   import dma_seq_pkg::*;
#(
   parameter bit SKIP_ADSTB = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        svc_req,
   input  logic        hold_ack,
   input  logic        ready,
   input  logic [1:0]  xfer_type,
   input  logic        block_mode,
   input  logic        hi_addr_chg,
   output logic        hold_req,
   output logic        bus_drive,
   output logic        aen,
   output logic        adstb,
   output logic        memr_n,
   output logic        memw_n,
   output logic        ior_n,
   output logic        iow_n,
   output logic        xfer_done
);

   initial begin
      assert (TYPE_W == 2) else $error("transfer type width must be 2");
      assert (NUM_STROBES == 4) else $error("four strobes expected");
   end

   seq_state_t             state;
   xfer_t                  cur_type;
   logic [NUM_STROBES-1:0] strb_act;

   dma_seq_fsm #(.SKIP_ADSTB(SKIP_ADSTB)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .svc_req     (svc_req),
      .hold_ack    (hold_ack),
      .ready       (ready),
      .block_mode  (block_mode),
      .hi_addr_chg (hi_addr_chg),
      .xfer_type   (xfer_type),
      .state       (state),
      .cur_type    (cur_type)
   );

   dma_seq_strobe u_strb (
      .state    (state),
      .cur_type (cur_type),
      .strb_act (strb_act)
   );

   assign hold_req  = (state != ST_IDLE);
   assign bus_drive = (state == ST_ADR) || (state == ST_ASSERT) ||
                      (state == ST_WAIT) || (state == ST_REL);
   assign aen       = bus_drive;
   assign adstb     = (state == ST_ADR);
   assign xfer_done = (state == ST_REL);
   assign memr_n    = ~strb_act[SB_MEMR];
   assign memw_n    = ~strb_act[SB_MEMW];
   assign ior_n     = ~strb_act[SB_IOR];
   assign iow_n     = ~strb_act[SB_IOW];

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
      !hold_req |-> (!bus_drive && memr_n && memw_n && ior_n && iow_n)); // R2
   AST_ADSTB_PULSE: assert property (@(posedge clk) disable iff (rst)
      adstb |=> !adstb); // R4
   AST_ADSTB_WITH_AEN: assert property (@(posedge clk) disable iff (rst)
      adstb |-> aen); // R4
   AST_READ_PAIR: assert property (@(posedge clk) disable iff (rst)
      !memr_n |-> (!iow_n && ior_n && memw_n)); // R5
   AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
      !ior_n |-> (!memw_n && memr_n && iow_n)); // R6
   AST_READY_STRETCH: assert property (@(posedge clk) disable iff (rst)
      (!memr_n && !ready) |=> !memr_n); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      xfer_done |=> !xfer_done); // R9
   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
      xfer_done |-> (memr_n && memw_n && ior_n && iow_n && aen)); // R9

endmodule

// File: tb/dma_cycle_seq_bench.sv
module dma_cycle_seq_bench;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst, svc_req, hold_drv, tie, ready, block_mode, hi_addr_chg;
   logic [1:0] xfer_type;
   logic       hold_ack;
   logic       hold_req, bus_drive, aen, adstb, memr_n, memw_n, ior_n, iow_n, xfer_done;

   assign hold_ack = tie ? hold_req : hold_drv;

   dma_cycle_seq u_dma_cycle_seq (
      .clk(clk), .rst(rst), .svc_req(svc_req), .hold_ack(hold_ack), .ready(ready),
      .xfer_type(xfer_type), .block_mode(block_mode), .hi_addr_chg(hi_addr_chg),
      .hold_req(hold_req), .bus_drive(bus_drive), .aen(aen), .adstb(adstb),
      .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .xfer_done(xfer_done)
   );

   // {hold_req,bus_drive,aen,adstb,memr_n,memw_n,ior_n,iow_n,xfer_done}
   localparam logic [8:0] O_IDLE = 9'b0_0_0_0_1111_0;
   localparam logic [8:0] O_REQ  = 9'b1_0_0_0_1111_0;
   localparam logic [8:0] O_ADR  = 9'b1_1_1_1_1111_0;
   localparam logic [8:0] O_RD   = 9'b1_1_1_0_0110_0;
   localparam logic [8:0] O_WR   = 9'b1_1_1_0_1001_0;
   localparam logic [8:0] O_VF   = 9'b1_1_1_0_1111_0;
   localparam logic [8:0] O_REL  = 9'b1_1_1_0_1111_1;

   int vectors = 0;
   int miscompares = 0;

   function automatic logic [8:0] obs();
      return {hold_req, bus_drive, aen, adstb, memr_n, memw_n, ior_n, iow_n, xfer_done};
   endfunction

   task automatic chk(string tag, logic [8:0] exp);
      logic [8:0] act;
      act = obs();
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst = 1'b1; svc_req = 1'b1; tie = 1'b1; hold_drv = 1'b0; ready = 1'b1;
      block_mode = 1'b0; hi_addr_chg = 1'b0; xfer_type = 2'b10;
      step(); step();
      chk("R1 outputs during reset", O_IDLE);
      svc_req = 1'b0;
      rst = 1'b0;
      step();
      chk("R1 idle after reset", O_IDLE);
      step();
      chk("R2 idle stays released", O_IDLE);
   endtask

   task automatic t_read();
      tie = 1'b1; xfer_type = 2'b10; ready = 1'b1; block_mode = 1'b0;
      svc_req = 1'b1;
      step(); chk("R3 one request cycle when tied", O_REQ);
      step(); chk("R4 address strobe state", O_ADR);
      svc_req = 1'b0;
      step(); chk("R5 read pair assert", O_RD);
      step(); chk("R5 read pair wait", O_RD);
      step(); chk("R9 done at release (read)", O_REL);
      step(); chk("R11 back to idle", O_IDLE);
   endtask

   task automatic t_write_hold_wait();
      tie = 1'b0; hold_drv = 1'b0; xfer_type = 2'b01; ready = 1'b1;
      svc_req = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step(); chk("R3 waits for hold_ack", O_REQ);
      end
      hold_drv = 1'b1;
      step(); chk("R4 grant enters address strobe", O_ADR);
      svc_req = 1'b0;
      xfer_type = 2'b10;
      step(); chk("R6 write pair assert / R12 type latched", O_WR);
      step(); chk("R6 write pair wait", O_WR);
      step(); chk("R9 done at release (write)", O_REL);
      hold_drv = 1'b0;
      step(); chk("R11 idle after write", O_IDLE);
      tie = 1'b1;
   endtask

   task automatic t_ready();
      xfer_type = 2'b10; svc_req = 1'b1;
      step(); chk("R8 req", O_REQ);
      step(); chk("R8 adr", O_ADR);
      svc_req = 1'b0; ready = 1'b0;
      for (int i = 0; i < 4; i++) begin
         step(); chk("R8 strobes held while ready low", O_RD);
      end
      ready = 1'b1;
      step(); chk("R8 release after ready", O_REL);
      step(); chk("R8 idle", O_IDLE);
   endtask

   task automatic t_verify(logic [1:0] code);
      xfer_type = code; svc_req = 1'b1; ready = 1'b0;
      step(); chk("R7 req", O_REQ);
      step(); chk("R7 adr", O_ADR);
      svc_req = 1'b0;
      step(); chk("R7 no strobes assert", O_VF);
      step(); chk("R7 no strobes wait", O_VF);
      step(); chk("R7 ready ignored, release", O_REL);
      step(); chk("R7 idle", O_IDLE);
      ready = 1'b1;
   endtask

   task automatic t_block();
      xfer_type = 2'b10; block_mode = 1'b1; svc_req = 1'b1; hi_addr_chg = 1'b0;
      step(); chk("R10 req", O_REQ);
      step(); chk("R10 first adr", O_ADR);
      step(); chk("R10 rd", O_RD);
      step(); chk("R10 rd", O_RD);
      step(); chk("R10 rel 1", O_REL);
      step(); chk("R10 skip adstb when unchanged", O_RD);
      step(); chk("R10 rd", O_RD);
      step(); chk("R10 rel 2", O_REL);
      hi_addr_chg = 1'b1;
      step(); chk("R10 adstb when upper byte changed", O_ADR);
      hi_addr_chg = 1'b0;
      step(); chk("R10 rd", O_RD);
      step(); chk("R10 rd", O_RD);
      step(); chk("R10 rel 3", O_REL);
      block_mode = 1'b0;
      step(); chk("R11 no chaining without block mode", O_IDLE);
      step(); chk("R3 new request from held svc", O_REQ);
      svc_req = 1'b0;
      step(); chk("R4 adr", O_ADR);
      step(); chk("R5 rd", O_RD);
      step(); chk("R5 rd", O_RD);
      step(); chk("R9 rel", O_REL);
      step(); chk("R11 idle", O_IDLE);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      t_reset();
      t_read();
      t_write_hold_wait();
      t_ready();
      t_verify(2'b00);
      t_verify(2'b11);
      t_block();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule